// File: doc/BRIEF.md
# Local Bus Slave Register Decoder with User-Window Relay

This block is the target side of a 32-bit local bus that hangs off a PCI bridge. Each host access arrives as a byte address with write data, byte enables and a one-cycle write or read request in the local-bus clock domain. The block sorts the address into one of three groups. The first is a user memory window at the bottom of the map. The second is a host-writable control register whose value is driven continuously to user logic. The third is a host-readable status word that user logic supplies.

Window accesses are handed over to user logic, which runs on its own clock at twice the local-bus rate. The block presents a word address, the write data and the byte enables, together with a single-cycle write or read strobe. It then waits for the user's acknowledge before it completes the host access. A toggle handshake carries the request into the user domain and carries the acknowledge back. Read data is captured into a register when the acknowledge arrives and stays there, so the slower domain can sample it late.

The host must keep at most one access outstanding. It issues the next request only after it has seen the completion pulse.

Top module: `lbs_slave`

## Requirements
- R1: While reset is asserted and directly after it, `ctrl_out`, `lb_ack`, `lb_rdata`, `u_wr` and `u_rd` are all zero.
- R2: A write to byte address 0x40000 with `lb_be` = 4'b1111 loads `lb_wdata` into the control register. The new value appears on `ctrl_out` and is returned by a read of 0x40000. Both accesses complete with `lb_ack` one local-bus cycle after the request.
- R3: On a control write, bit i of `lb_be` updates only byte lane i (bits 8i+7..8i). Lanes whose enable is clear keep their old value.
- R4: A read of byte address 0x40040 returns the value on `status_in`.
- R5: Any other address at or above 0x40000 is unmapped. A read of it returns zero, a write to it changes nothing, and both complete one cycle after the request without raising a user strobe.
- R6: A write to a byte address from 0x000000 to 0x03FFFC raises `u_wr` with `u_addr` = byte address >> 2, together with `u_wdata` and `u_be`. `u_wr` and `u_rd` are never high together. The host write completes only after `u_ack`.
- R7: A read in the window raises `u_rd`. `lb_ack` does not rise until the user has returned `u_ack`, and `lb_rdata` then carries the `u_rdata` value sampled with that acknowledge.
- R8: Every `u_wr` and `u_rd` strobe is exactly one user-clock cycle wide, and each window access produces exactly one strobe.
- R9: `lb_ack` is a one-cycle pulse. The read data it completes stays on `lb_rdata` after the pulse, until the next read.
- R10: Reset abandons a window access that is still waiting for `u_ack`. No late completion appears, the control register returns to zero, and the next window access behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lclk | input | 1 | Local-bus clock |
| uclk | input | 1 | User clock, twice the local-bus rate |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| lb_addr | input | 20 | Host byte address |
| lb_wdata | input | 32 | Host write data |
| lb_be | input | 4 | Host byte enables, bit i = lane i |
| lb_wr | input | 1 | One-cycle host write request |
| lb_rd | input | 1 | One-cycle host read request |
| lb_rdata | output | 32 | Read data returned to the host |
| lb_ack | output | 1 | One-cycle completion pulse |
| ctrl_out | output | 32 | Control register value |
| status_in | input | 32 | Status word from user logic |
| u_addr | output | 16 | Window word address |
| u_wdata | output | 32 | Window write data |
| u_be | output | 4 | Window byte enables |
| u_wr | output | 1 | Window write strobe (user clock) |
| u_rd | output | 1 | Window read strobe (user clock) |
| u_rdata | input | 32 | Read data from user logic |
| u_ack | input | 1 | User acknowledge |

## Verification
The bench slows the user acknowledge down to many user cycles. A decoder that completed window reads early would finish them before the data existed and return stale words. It also writes to the control register with a sparse byte-enable pattern, which catches lane steering that is swapped or that ignores the enables. Unmapped register addresses are checked for a zero result, a one-cycle completion and no stray user strobe. Finally, reset is pulled in the middle of an unanswered window read: a design that kept the pending toggle would give a phantom completion or lose the next strobe. The last window word at the top of the map and the hold of `lb_rdata` after the completion pulse are also checked.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

   typedef enum logic [1:0] {
      SEL_WIN  = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } lbs_sel_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } lbs_state_e;

endpackage

// File: rtl/lbs_sync.sv
module lbs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lbs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/lbs_decode.sv
module lbs_decode
   import lbs_pkg::*;
#(
   parameter int          ADDR_W    = 20,
   parameter int          LANE_BITS = 2,
   parameter int unsigned WIN_BYTES = 32'h40000,
   parameter int unsigned CTRL_ADDR = 32'h40000,
   parameter int unsigned STAT_ADDR = 32'h40040
) (
   input  logic [ADDR_W-1:0] addr,
   output lbs_sel_e          sel
);
   localparam logic [ADDR_W-1:0] WIN_L  = ADDR_W'(WIN_BYTES);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

   logic [ADDR_W-LANE_BITS-1:0] word;
   assign word = addr[ADDR_W-1:LANE_BITS];

   always_comb begin
      if (addr < WIN_L)                           sel = SEL_WIN;
      else if (word == CTRL_A[ADDR_W-1:LANE_BITS]) sel = SEL_CTRL;
      else if (word == STAT_A[ADDR_W-1:LANE_BITS]) sel = SEL_STAT;
      else                                         sel = SEL_NONE;
   end
endmodule

// File: rtl/lbs_ctrl_reg.sv
module lbs_ctrl_reg #(
   parameter int                  DATA_W    = 32,
   parameter int                  BE_W      = DATA_W / 8,
   parameter logic [DATA_W-1:0]   RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [BE_W-1:0]   be,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   for (genvar i = 0; i < BE_W; i++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            lane_q <= RESET_VAL[i*8 +: 8];
         else if (we && be[i])  lane_q <= wdata[i*8 +: 8];
      end
      assign q[i*8 +: 8] = lane_q;
   end
endmodule

// File: rtl/lbs_ureq.sv
module lbs_ureq #(
   parameter int DATA_W = 32,
   parameter int STAGES = 2
) (
   input  logic              uclk,
   input  logic              rst_n,
   input  logic              req_tgl,
   input  logic              req_is_wr,
   input  logic              u_ack,
   input  logic [DATA_W-1:0] u_rdata,
   output logic              u_wr,
   output logic              u_rd,
   output logic              ack_tgl,
   output logic [DATA_W-1:0] rdata_q
);
   logic req_s;
   logic req_seen;
   logic busy;
   logic new_req;

   lbs_sync #(.STAGES(STAGES)) u_req_sync (
      .clk   (uclk),
      .rst_n (rst_n),
      .d     (req_tgl),
      .q     (req_s)
   );

   assign new_req = (req_s != req_seen) && !busy;

   always_ff @(posedge uclk or negedge rst_n) begin
      if (!rst_n) begin
         req_seen <= 1'b0;
         busy     <= 1'b0;
         u_wr     <= 1'b0;
         u_rd     <= 1'b0;
         ack_tgl  <= 1'b0;
         rdata_q  <= '0;
      end else begin
         u_wr <= 1'b0;
         u_rd <= 1'b0;
         if (new_req) begin
            req_seen <= req_s;
            busy     <= 1'b1;
            u_wr     <= req_is_wr;
            u_rd     <= !req_is_wr;
         end else if (busy && u_ack) begin
            busy    <= 1'b0;
            ack_tgl <= !ack_tgl;
            if (!req_is_wr) rdata_q <= u_rdata;
         end
      end
   end
endmodule

// File: rtl/lbs_slave.sv
module lbs_slave
   import lbs_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 20,
   parameter int          UWORD_W   = 16,
   parameter int unsigned WIN_BYTES = 32'h40000,
   parameter int unsigned CTRL_ADDR = 32'h40000,
   parameter int unsigned STAT_ADDR = 32'h40040,
   parameter int          SYNC_STG  = 2
) (
   input  logic                  lclk,
   input  logic                  uclk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     lb_addr,
   input  logic [DATA_W-1:0]     lb_wdata,
   input  logic [DATA_W/8-1:0]   lb_be,
   input  logic                  lb_wr,
   input  logic                  lb_rd,
   output logic [DATA_W-1:0]     lb_rdata,
   output logic                  lb_ack,
   output logic [DATA_W-1:0]     ctrl_out,
   input  logic [DATA_W-1:0]     status_in,
   output logic [UWORD_W-1:0]    u_addr,
   output logic [DATA_W-1:0]     u_wdata,
   output logic [DATA_W/8-1:0]   u_be,
   output logic                  u_wr,
   output logic                  u_rd,
   input  logic [DATA_W-1:0]     u_rdata,
   input  logic                  u_ack
);
   localparam int BE_W      = DATA_W / 8;
   localparam int LANE_BITS = $clog2(BE_W);
   localparam longint WIN_WORDS = longint'(WIN_BYTES) / BE_W;

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
      $error("lbs_slave: DATA_W must be a multiple of 8 and at least 16");
   end
   if (WIN_WORDS > (longint'(1) << UWORD_W)) begin : g_bad_window
      $error("lbs_slave: window does not fit the user word address");
   end
   if (CTRL_ADDR < WIN_BYTES || STAT_ADDR < WIN_BYTES || CTRL_ADDR == STAT_ADDR) begin : g_bad_map
      $error("lbs_slave: register addresses must be distinct and above the window");
   end
   if (longint'(STAT_ADDR) >= (longint'(1) << ADDR_W)) begin : g_bad_addr
      $error("lbs_slave: ADDR_W too narrow for the register map");
   end

   lbs_sel_e   sel;
   lbs_state_e state;
   logic       ctrl_we;
   logic       req_tgl;
   logic       ack_tgl;
   logic       ack_s;
   logic       ack_seen;
   logic       hold_wr;
   logic [UWORD_W-1:0] hold_addr;
   logic [DATA_W-1:0]  hold_data;
   logic [BE_W-1:0]    hold_be;
   logic [DATA_W-1:0]  win_rdata;

   lbs_decode #(
      .ADDR_W    (ADDR_W),
      .LANE_BITS (LANE_BITS),
      .WIN_BYTES (WIN_BYTES),
      .CTRL_ADDR (CTRL_ADDR),
      .STAT_ADDR (STAT_ADDR)
   ) u_decode (
      .addr (lb_addr),
      .sel  (sel)
   );

   assign ctrl_we = (state == ST_IDLE) && lb_wr && (sel == SEL_CTRL);

   lbs_ctrl_reg #(
      .DATA_W    (DATA_W),
      .BE_W      (BE_W),
      .RESET_VAL ('0)
   ) u_ctrl (
      .clk   (lclk),
      .rst_n (rst_n),
      .we    (ctrl_we),
      .be    (lb_be),
      .wdata (lb_wdata),
      .q     (ctrl_out)
   );

   lbs_sync #(.STAGES(SYNC_STG)) u_ack_sync (
      .clk   (lclk),
      .rst_n (rst_n),
      .d     (ack_tgl),
      .q     (ack_s)
   );

   always_ff @(posedge lclk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         lb_ack    <= 1'b0;
         lb_rdata  <= '0;
         req_tgl   <= 1'b0;
         ack_seen  <= 1'b0;
         hold_wr   <= 1'b0;
         hold_addr <= '0;
         hold_data <= '0;
         hold_be   <= '0;
      end else begin
         lb_ack <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (lb_wr || lb_rd) begin
                  if (sel == SEL_WIN) begin
                     hold_wr   <= lb_wr;
                     hold_addr <= UWORD_W'(lb_addr >> LANE_BITS);
                     hold_data <= lb_wdata;
                     hold_be   <= lb_be;
                     req_tgl   <= !req_tgl;
                     state     <= ST_WAIT;
                  end else begin
                     lb_ack <= 1'b1;
                     if (!lb_wr) begin
                        unique case (sel)
                           SEL_CTRL: lb_rdata <= ctrl_out;
                           SEL_STAT: lb_rdata <= status_in;
                           default:  lb_rdata <= '0;
                        endcase
                     end
                  end
               end
            end
            ST_WAIT: begin
               if (ack_s != ack_seen) begin
                  ack_seen <= ack_s;
                  lb_ack   <= 1'b1;
                  state    <= ST_IDLE;
                  if (!hold_wr) lb_rdata <= win_rdata;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign u_addr  = hold_addr;
   assign u_wdata = hold_data;
   assign u_be    = hold_be;

   lbs_ureq #(
      .DATA_W (DATA_W),
      .STAGES (SYNC_STG)
   ) u_ureq (
      .uclk      (uclk),
      .rst_n     (rst_n),
      .req_tgl   (req_tgl),
      .req_is_wr (hold_wr),
      .u_ack     (u_ack),
      .u_rdata   (u_rdata),
      .u_wr      (u_wr),
      .u_rd      (u_rd),
      .ack_tgl   (ack_tgl),
      .rdata_q   (win_rdata)
   );
endmodule

// File: rtl/lbs_slave_chk.sv
module lbs_slave_chk #(
   parameter int DATA_W = 32
) (
   input logic              lclk,
   input logic              uclk,
   input logic              rst_n,
   input logic              lb_wr,
   input logic              lb_ack,
   input logic [DATA_W-1:0] lb_rdata,
   input logic [DATA_W-1:0] ctrl_out,
   input logic              u_wr,
   input logic              u_rd
);
   p_wr_pulse_r8: assert property (@(posedge uclk) disable iff (!rst_n)
      u_wr |=> !u_wr);

   p_rd_pulse_r8: assert property (@(posedge uclk) disable iff (!rst_n)
      u_rd |=> !u_rd);

   p_one_dir_r6: assert property (@(posedge uclk) disable iff (!rst_n)
      !(u_wr && u_rd));

   p_ctrl_quiet_r2: assert property (@(posedge lclk) disable iff (!rst_n)
      !lb_wr |=> $stable(ctrl_out));

   p_ack_single_r9: assert property (@(posedge lclk) disable iff (!rst_n)
      lb_ack |=> !lb_ack);

   p_rdata_hold_r9: assert property (@(posedge lclk) disable iff (!rst_n)
      lb_ack |=> $stable(lb_rdata));
endmodule

bind lbs_slave lbs_slave_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/lbs_slave_tb.sv
`timescale 1ns/1ps
module lbs_slave_tb;
   logic        lclk = 1'b0;
   logic        uclk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] lb_addr = '0;
   logic [31:0] lb_wdata = '0;
   logic [3:0]  lb_be = '0;
   logic        lb_wr = 1'b0;
   logic        lb_rd = 1'b0;
   logic [31:0] lb_rdata;
   logic        lb_ack;
   logic [31:0] ctrl_out;
   logic [31:0] status_in = 32'h5EED0042;
   logic [15:0] u_addr;
   logic [31:0] u_wdata;
   logic [3:0]  u_be;
   logic        u_wr;
   logic        u_rd;
   logic [31:0] u_rdata = '0;
   logic        u_ack = 1'b0;

   int total = 0;
   int bad = 0;
   int strobes = 0;
   int wide = 0;
   int resp_dly = 2;
   bit resp_en = 1'b1;
   bit cap_wr;
   logic [15:0] cap_addr;
   logic [31:0] cap_data;
   logic [3:0]  cap_be;

   always #2.5 uclk = ~uclk;
   always #5   lclk = ~lclk;

   lbs_slave u_dut (
      .lclk(lclk), .uclk(uclk), .rst_n(rst_n),
      .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_be(lb_be),
      .lb_wr(lb_wr), .lb_rd(lb_rd), .lb_rdata(lb_rdata), .lb_ack(lb_ack),
      .ctrl_out(ctrl_out), .status_in(status_in),
      .u_addr(u_addr), .u_wdata(u_wdata), .u_be(u_be),
      .u_wr(u_wr), .u_rd(u_rd), .u_rdata(u_rdata), .u_ack(u_ack)
   );

   function automatic logic [31:0] pattern(input logic [15:0] a);
      return {16'hA5C3, a};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // user-side responder
   initial begin
      forever begin
         @(posedge uclk); #1;
         if (u_wr || u_rd) begin
            strobes++;
            cap_wr   = u_wr;
            cap_addr = u_addr;
            cap_data = u_wdata;
            cap_be   = u_be;
            @(posedge uclk); #1;
            if (u_wr || u_rd) wide++;
            if (resp_en) begin
               repeat (resp_dly) @(posedge uclk);
               #1;
               u_ack   = 1'b1;
               u_rdata = pattern(cap_addr);
               @(posedge uclk); #1;
               u_ack   = 1'b0;
               u_rdata = '0;
            end
         end
      end
   end

   task automatic lb_issue(input bit wr, input logic [19:0] a, input logic [31:0] d, input logic [3:0] be);
      @(posedge lclk); #1;
      lb_addr = a; lb_wdata = d; lb_be = be;
      lb_wr = wr; lb_rd = !wr;
      @(posedge lclk); #1;
      lb_wr = 1'b0; lb_rd = 1'b0;
   endtask

   // returns latency in local cycles from request edge to lb_ack; checks R9 hold
   task automatic lb_xfer(input bit wr, input logic [19:0] a, input logic [31:0] d,
                          input logic [3:0] be, output logic [31:0] rd, output int lat);
      lb_issue(wr, a, d, be);
      lat = 1;
      while (!lb_ack && lat < 200) begin
         @(posedge lclk); #1;
         lat++;
      end
      if (!lb_ack) begin
         total++; bad++;
         $display("FAIL R7: actual=no completion expected=lb_ack");
      end
      rd = lb_rdata;
      @(posedge lclk); #1;
      chk("R9 ack one cycle", {31'b0, lb_ack}, 32'd0);
      chk("R9 rdata held", lb_rdata, rd);
   endtask

   task automatic t_reset;
      chk("R1 ctrl_out", ctrl_out, 32'd0);
      chk("R1 lb_ack", {31'b0, lb_ack}, 32'd0);
      chk("R1 lb_rdata", lb_rdata, 32'd0);
      chk("R1 strobes", {30'b0, u_wr, u_rd}, 32'd0);
   endtask

   task automatic t_ctrl;
      logic [31:0] rd; int lat;
      lb_xfer(1'b1, 20'h40000, 32'hCAFE1234, 4'hF, rd, lat);
      chk("R2 ctrl_out after write", ctrl_out, 32'hCAFE1234);
      chk("R2 write latency", lat, 1);
      lb_xfer(1'b0, 20'h40000, '0, 4'hF, rd, lat);
      chk("R2 read back", rd, 32'hCAFE1234);
      chk("R2 read latency", lat, 1);
   endtask

   task automatic t_be;
      logic [31:0] rd; int lat;
      lb_xfer(1'b1, 20'h40000, 32'h11223344, 4'b0101, rd, lat);
      chk("R3 lanes 0 and 2", ctrl_out, 32'hCA221244);
      lb_xfer(1'b1, 20'h40000, 32'hFFFFFFFF, 4'b0000, rd, lat);
      chk("R3 no lanes", ctrl_out, 32'hCA221244);
      lb_xfer(1'b1, 20'h40000, 32'h99887766, 4'b1000, rd, lat);
      chk("R3 lane 3", ctrl_out, 32'h99221244);
   endtask

   task automatic t_status;
      logic [31:0] rd; int lat;
      lb_xfer(1'b0, 20'h40040, '0, 4'hF, rd, lat);
      chk("R4 status read", rd, 32'h5EED0042);
      status_in = 32'h0BADF00D;
      repeat (2) @(posedge lclk);
      lb_xfer(1'b0, 20'h40040, '0, 4'hF, rd, lat);
      chk("R4 status follows input", rd, 32'h0BADF00D);
   endtask

   task automatic t_unmapped;
      logic [31:0] rd; int lat; int s0;
      s0 = strobes;
      lb_xfer(1'b0, 20'h40080, '0, 4'hF, rd, lat);
      chk("R5 unmapped read zero", rd, 32'd0);
      chk("R5 unmapped latency", lat, 1);
      lb_xfer(1'b0, 20'h40004, '0, 4'hF, rd, lat);
      chk("R5 unmapped 0x40004 zero", rd, 32'd0);
      lb_xfer(1'b1, 20'h40080, 32'h12345678, 4'hF, rd, lat);
      chk("R5 unmapped write ignored", ctrl_out, 32'h99221244);
      repeat (4) @(posedge uclk);
      chk("R5 no user strobe", strobes, s0);
   endtask

   task automatic t_win_wr;
      logic [31:0] rd; int lat; int s0;
      s0 = strobes;
      resp_dly = 2;
      lb_xfer(1'b1, 20'h00124, 32'hDEADBEEF, 4'b0011, rd, lat);
      chk("R6 one strobe", strobes, s0 + 1);
      chk("R6 dir write", {31'b0, cap_wr}, 32'd1);
      chk("R6 word addr", {16'b0, cap_addr}, 32'h49);
      chk("R6 wdata", cap_data, 32'hDEADBEEF);
      chk("R6 be", {28'b0, cap_be}, 32'h3);
      lb_xfer(1'b1, 20'h3FFFC, 32'h0F0F0F0F, 4'hF, rd, lat);
      chk("R6 top word addr", {16'b0, cap_addr}, 32'hFFFF);
      chk("R6 ctrl untouched", ctrl_out, 32'h99221244);
   endtask

   task automatic t_win_rd;
      logic [31:0] rd; int lat; int s0;
      s0 = strobes;
      resp_dly = 3;
      lb_xfer(1'b0, 20'h00010, '0, 4'hF, rd, lat);
      chk("R7 read data", rd, pattern(16'h0004));
      chk("R7 dir read", {31'b0, cap_wr}, 32'd0);
      resp_dly = 20;
      lb_xfer(1'b0, 20'h3FFFC, '0, 4'hF, rd, lat);
      chk("R7 slow read data", rd, pattern(16'hFFFF));
      total++;
      if (lat < 10) begin
         bad++;
         $display("FAIL R7 early completion: actual=%0d expected>=10", lat);
      end
      chk("R8 one strobe per access", strobes, s0 + 2);
      resp_dly = 2;
   endtask

   task automatic t_reset_drop;
      logic [31:0] rd; int lat; int s0;
      resp_en = 1'b0;
      lb_issue(1'b0, 20'h00040, '0, 4'hF);
      repeat (20) @(posedge lclk);
      #1;
      chk("R10 no completion without ack", {31'b0, lb_ack}, 32'd0);
      rst_n = 1'b0;
      repeat (3) @(posedge lclk);
      #1;
      chk("R10 ctrl cleared", ctrl_out, 32'd0);
      rst_n = 1'b1;
      resp_en = 1'b1;
      repeat (20) @(posedge lclk);
      #1;
      chk("R10 no late completion", {31'b0, lb_ack}, 32'd0);
      s0 = strobes;
      lb_xfer(1'b0, 20'h00080, '0, 4'hF, rd, lat);
      chk("R10 next read data", rd, pattern(16'h0020));
      chk("R10 next read one strobe", strobes, s0 + 1);
   endtask

   initial begin
      #1000000;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(posedge lclk);
      #1;
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(posedge lclk);
      #1;
      t_reset();
      t_ctrl();
      t_be();
      t_status();
      t_unmapped();
      t_win_wr();
      t_win_rd();
      t_reset_drop();
      chk("R8 strobes single cycle", wide, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule